// File: doc/BRIEF.md
# Byte-Point Interrupt and Clock-Stretch Controller for a Two-Wire Serial Bus

This block sits beside the bit engine of a two-wire serial port (I2C). It sees the decoded bus as single-cycle strobes in the system clock domain: a strobe for each falling edge of the serial clock, a strobe when a start or repeated start is detected, and a strobe when a stop is detected. It counts clock falls within each byte frame, which is eight data bits followed by one acknowledge bit. From that count, the role (controller or target), the address-compare result, the extension-code flag and the repeated-start flag, it decides on which fall of the frame a one-cycle interrupt pulse is raised. It also decides whether the serial clock is then held low so that software can service the byte.

The timing-select input picks the event point for data frames: the eighth fall (before the acknowledge bit) or the ninth fall (after it). Address frames follow fixed rules. In controller mode the event is always at the ninth fall. In target mode the point depends on the compare result. A held clock is let go when software pulses the wait-release strobe or the shift-register write strobe. In controller mode a start request or a stop request also lets it go. At each release the block captures the acknowledge level that software has prepared.

Top module: `i2c_byte_wait_ctrl`

## Requirements
- R1: During and right after reset, `irq`, `scl_hold`, `ack_force` and `ack_lvl` are all 0.
- R2: With `master_mode`=1, the address frame (the first frame after a start) raises `irq` and `scl_hold` on its 9th fall only, for either value of `late_sel`. Outputs are registered, so they change in the cycle after the `scl_fall` strobe.
- R3: In a data frame of a controller, or of a target selected in the address frame, `late_sel`=0 puts the event (irq plus hold) on the 8th fall and `late_sel`=1 puts it on the 9th fall.
- R4: Target with `addr_match`=1 in the address frame: the event (irq plus hold) is on the 9th fall. `ack_force` is 1 from the 8th fall until the 9th fall, whatever the acknowledge-enable setting.
- R5: Target with `addr_match`=0 and `ext_code`=1 in the address frame: the event (irq plus hold) is on the 8th fall.
- R6: Target with no match, no extension code and `restart_flag`=0: there is no irq and no hold in the address frame or in any data frame that follows before the next start.
- R7: Target with no match and no extension code after a repeated start (`restart_flag`=1): `irq` pulses on the 9th fall and `scl_hold` stays 0.
- R8: A pulse on `rel_wait` or `rel_wr` while the clock is held clears `scl_hold` one cycle later and loads `ack_lvl` with `ack_level`.
- R9: `rel_start_req` and `rel_stop_req` release the hold in controller mode and have no effect in target mode.
- R10: `stop_det` clears `scl_hold`. `start_det` restarts the fall count, so the next fall is fall 1 of an address frame. Fall counts wrap from 9 to 1.
- R11: When a release strobe arrives in the same cycle as a new wait event, the new wait wins and `scl_hold` stays 1. The prior hold's release still loads `ack_lvl`.
- R12: `irq` is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_fall | input | 1 | One-cycle strobe per serial-clock falling edge |
| start_det | input | 1 | Start or repeated start detected |
| stop_det | input | 1 | Stop condition detected |
| late_sel | input | 1 | Data-frame event point: 0 = 8th fall, 1 = 9th fall |
| master_mode | input | 1 | 1 = controller role, 0 = target role |
| addr_match | input | 1 | Received address equals own address |
| ext_code | input | 1 | Received address is an extension code |
| restart_flag | input | 1 | Current address frame follows a repeated start |
| ack_level | input | 1 | Acknowledge level prepared by software |
| rel_wait | input | 1 | Software wait-release strobe |
| rel_wr | input | 1 | Shift-register write strobe |
| rel_start_req | input | 1 | Software start request (releases in controller mode) |
| rel_stop_req | input | 1 | Software stop request (releases in controller mode) |
| irq | output | 1 | One-cycle per-byte interrupt pulse |
| scl_hold | output | 1 | Hold serial clock low (wait) |
| ack_force | output | 1 | Force an acknowledge for a matched target address |
| ack_lvl | output | 1 | Acknowledge level captured at the last release |

## Verification
The two functions that can meet in one cycle are the release of an existing hold and the setting of a new one. This happens when a wait left open from one data frame is released by `rel_wait` on the exact fall that is the next frame's event point. The bench provokes it by leaving a 9th-fall hold pending and then pulsing the release with the 8th fall of a following `late_sel`=0 frame. It expects `scl_hold` to stay 1 and `ack_lvl` to take the new acknowledge level. Stop arriving together with a pending hold is judged the same way, with the hold expected to clear.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    EVT_NONE     = 2'd0,
    EVT_IRQ_ONLY = 2'd1,
    EVT_IRQ_WAIT = 2'd2
  } evt_kind_e;
endpackage

// File: rtl/i2cw_bitcnt.sv
module i2cw_bitcnt #(
  parameter int BITS  = 8,
  localparam int FRAME = BITS + 1,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic [CNT_W-1:0] fall_idx,
  output logic             fall_evt,
  output logic             addr_phase
);
  logic [CNT_W-1:0] cnt_q;

  assign fall_idx = (cnt_q == CNT_W'(FRAME)) ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign fall_evt = scl_fall && !start_det && !stop_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      addr_phase <= 1'b0;
    end else if (start_det) begin
      cnt_q      <= '0;
      addr_phase <= 1'b1;
    end else if (stop_det) begin
      cnt_q      <= '0;
      addr_phase <= 1'b0;
    end else if (scl_fall) begin
      cnt_q <= fall_idx;
      if (fall_idx == CNT_W'(FRAME)) addr_phase <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME)); // R10
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (cnt_q == '0) && addr_phase); // R10
endmodule

// File: rtl/i2cw_event.sv
module i2cw_event
  import i2cw_pkg::*;
#(
  parameter int BITS  = 8,
  localparam int FRAME = BITS + 1,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fall_idx,
  input  logic             fall_evt,
  input  logic             addr_phase,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             late_sel,
  input  logic             master_mode,
  input  logic             addr_match,
  input  logic             ext_code,
  input  logic             restart_flag,
  output evt_kind_e        kind,
  output logic             ack_force_q
);
  logic at_ack_pre;
  logic at_ack_post;
  logic data_hit;
  logic sel_q;

  assign at_ack_pre  = fall_evt && (fall_idx == CNT_W'(BITS));
  assign at_ack_post = fall_evt && (fall_idx == CNT_W'(FRAME));
  assign data_hit    = late_sel ? at_ack_post : at_ack_pre;

  always_comb begin
    kind = EVT_NONE;
    if (master_mode) begin
      if (addr_phase) begin
        if (at_ack_post) kind = EVT_IRQ_WAIT;
      end else if (data_hit) begin
        kind = EVT_IRQ_WAIT;
      end
    end else if (addr_phase) begin
      if (addr_match) begin
        if (at_ack_post) kind = EVT_IRQ_WAIT;
      end else if (ext_code) begin
        if (at_ack_pre) kind = EVT_IRQ_WAIT;
      end else if (restart_flag) begin
        if (at_ack_post) kind = EVT_IRQ_ONLY;
      end
    end else if (sel_q && data_hit) begin
      kind = EVT_IRQ_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= 1'b0;
      ack_force_q <= 1'b0;
    end else if (start_det || stop_det) begin
      sel_q       <= 1'b0;
      ack_force_q <= 1'b0;
    end else begin
      if (!master_mode && addr_phase && at_ack_pre && (addr_match || ext_code))
        sel_q <= 1'b1;
      if (!master_mode && addr_phase && at_ack_pre && addr_match)
        ack_force_q <= 1'b1;
      else if (at_ack_post)
        ack_force_q <= 1'b0;
    end
  end

  AST_ACKF_TARGET_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_force_q) |-> $past(!master_mode) && $past(addr_match)); // R4
  AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !addr_phase && !sel_q) |-> kind == EVT_NONE); // R6
endmodule

// File: rtl/i2cw_hold.sv
module i2cw_hold (
  input  logic clk,
  input  logic rst,
  input  logic evt_wait,
  input  logic stop_det,
  input  logic master_mode,
  input  logic rel_wait,
  input  logic rel_wr,
  input  logic rel_start_req,
  input  logic rel_stop_req,
  input  logic ack_level,
  output logic hold_q,
  output logic ack_lvl_q
);
  logic rel_any;

  assign rel_any = rel_wait || rel_wr ||
                   (master_mode && (rel_start_req || rel_stop_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b0;
      ack_lvl_q <= 1'b0;
    end else begin
      if (rel_any && hold_q && !stop_det) ack_lvl_q <= ack_level;
      if (stop_det)      hold_q <= 1'b0;
      else if (evt_wait) hold_q <= 1'b1;
      else if (rel_any)  hold_q <= 1'b0;
    end
  end

  AST_TARGET_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !master_mode && !rel_wait && !rel_wr && !stop_det) |=> hold_q); // R9
  AST_CTRL_REQ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (master_mode && rel_stop_req && !evt_wait) |=> !hold_q); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !hold_q); // R10
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt_wait && !stop_det) |=> hold_q); // R11
endmodule

// File: rtl/i2c_byte_wait_ctrl.sv
module i2c_byte_wait_ctrl
  import i2cw_pkg::*;
#(
  parameter int BITS = 8,
  localparam int FRAME = BITS + 1,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  logic late_sel,
  input  logic master_mode,
  input  logic addr_match,
  input  logic ext_code,
  input  logic restart_flag,
  input  logic ack_level,
  input  logic rel_wait,
  input  logic rel_wr,
  input  logic rel_start_req,
  input  logic rel_stop_req,
  output logic irq,
  output logic scl_hold,
  output logic ack_force,
  output logic ack_lvl
);
  logic [CNT_W-1:0] fall_idx;
  logic             fall_evt;
  logic             addr_phase;
  evt_kind_e        kind;
  logic             irq_q;

  i2cw_bitcnt #(.BITS(BITS)) u_cnt (
    .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .fall_idx(fall_idx), .fall_evt(fall_evt),
    .addr_phase(addr_phase)
  );

  i2cw_event #(.BITS(BITS)) u_evt (
    .clk(clk), .rst(rst), .fall_idx(fall_idx), .fall_evt(fall_evt),
    .addr_phase(addr_phase), .start_det(start_det), .stop_det(stop_det),
    .late_sel(late_sel), .master_mode(master_mode), .addr_match(addr_match),
    .ext_code(ext_code), .restart_flag(restart_flag), .kind(kind),
    .ack_force_q(ack_force)
  );

  i2cw_hold u_hold (
    .clk(clk), .rst(rst), .evt_wait(kind == EVT_IRQ_WAIT), .stop_det(stop_det),
    .master_mode(master_mode), .rel_wait(rel_wait), .rel_wr(rel_wr),
    .rel_start_req(rel_start_req), .rel_stop_req(rel_stop_req),
    .ack_level(ack_level), .hold_q(scl_hold), .ack_lvl_q(ack_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (kind != EVT_NONE);
  end
  assign irq = irq_q;

  AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(scl_fall)); // R12
  AST_HOLD_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold) |-> irq_q); // R2
endmodule

// File: tb/i2c_byte_wait_ctrl_tb.sv
module i2c_byte_wait_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_fall = 0, start_det = 0, stop_det = 0, late_sel = 0;
  logic master_mode = 0, addr_match = 0, ext_code = 0, restart_flag = 0;
  logic ack_level = 0, rel_wait = 0, rel_wr = 0, rel_start_req = 0, rel_stop_req = 0;
  logic irq, scl_hold, ack_force, ack_lvl;

  always #4 clk = ~clk;  // 125 MHz

  i2c_byte_wait_ctrl u_dut (
    .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .late_sel(late_sel), .master_mode(master_mode),
    .addr_match(addr_match), .ext_code(ext_code), .restart_flag(restart_flag),
    .ack_level(ack_level), .rel_wait(rel_wait), .rel_wr(rel_wr),
    .rel_start_req(rel_start_req), .rel_stop_req(rel_stop_req),
    .irq(irq), .scl_hold(scl_hold), .ack_force(ack_force), .ack_lvl(ack_lvl)
  );

  typedef struct {
    int    cyc;
    logic  e_irq, e_hold, e_af, e_ack;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic x_hold = 0, x_ack = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop and compare items due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ({irq, scl_hold, ack_force, ack_lvl} !== {e.e_irq, e.e_hold, e.e_af, e.e_ack}) begin
        n_fail++;
        $display("FAIL %s: irq/hold/af/ack actual %b%b%b%b expected %b%b%b%b",
                 e.tag, irq, scl_hold, ack_force, ack_lvl,
                 e.e_irq, e.e_hold, e.e_af, e.e_ack);
      end
    end
  end

  // driver: push expectation for the next cycle, then advance and clear strobes
  task automatic tick(input logic ei, input logic eaf, input string tag);
    exp_t e;
    e.cyc = cyc + 1; e.e_irq = ei; e.e_hold = x_hold; e.e_af = eaf;
    e.e_ack = x_ack; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    scl_fall = 0; start_det = 0; stop_det = 0; rel_wait = 0; rel_wr = 0;
    rel_start_req = 0; rel_stop_req = 0;
  endtask

  // one frame: ev = event fall (0 none), w = event holds, af = forced-ack window,
  // rel_at = fall on which rel_wait is pulsed (0 none)
  task automatic frame(input int ev, input bit w, input bit af,
                       input int rel_at, input string tag);
    for (int i = 1; i <= 9; i++) begin
      scl_fall = 1;
      if (i == rel_at) begin
        rel_wait = 1;
        if (x_hold) x_ack = ack_level;
        x_hold = 0;
      end
      if (i == ev && w) x_hold = 1;
      tick(i == ev, af && i == 8, tag);
      tick(1'b0, af && i == 8, {tag, " R12"});
    end
  endtask

  task automatic do_start(input string tag);
    start_det = 1; tick(1'b0, 1'b0, tag);
  endtask

  task automatic do_stop(input string tag);
    stop_det = 1; x_hold = 0; tick(1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tick(1'b0, 1'b0, "R1 reset");
    rst = 0;
    tick(1'b0, 1'b0, "R1 after reset");

    // controller
    master_mode = 1; late_sel = 0;
    do_start("R10 start");
    frame(9, 1, 0, 0, "R2 addr late_sel=0");
    ack_level = 1; rel_wait = 1; x_hold = 0; x_ack = 1;
    tick(1'b0, 1'b0, "R8 rel_wait");
    frame(8, 1, 0, 0, "R3 data 8th");
    ack_level = 0; rel_wr = 1; x_hold = 0; x_ack = 0;
    tick(1'b0, 1'b0, "R8 rel_wr");
    late_sel = 1;
    frame(9, 1, 0, 0, "R3 data 9th");
    ack_level = 1; rel_stop_req = 1; x_hold = 0; x_ack = 1;
    tick(1'b0, 1'b0, "R9 ctrl stop req");
    frame(9, 1, 0, 0, "R3 data 9th b");
    ack_level = 0; rel_start_req = 1; x_hold = 0; x_ack = 0;
    tick(1'b0, 1'b0, "R9 ctrl start req");
    frame(9, 1, 0, 0, "R3 data pend");
    late_sel = 0; ack_level = 1;
    frame(8, 1, 0, 8, "R11 release meets event");
    do_stop("R10 stop clears");
    late_sel = 1;
    do_start("R10 start");
    frame(9, 1, 0, 0, "R2 addr late_sel=1");
    do_stop("R10 stop clears b");

    // restart mid-frame resets count
    late_sel = 0;
    do_start("R10 start");
    for (int i = 0; i < 4; i++) begin scl_fall = 1; tick(1'b0, 1'b0, "R10 partial"); end
    do_start("R10 restart");
    frame(9, 1, 0, 0, "R10 count from restart");
    do_stop("R10 stop");

    // target, address match
    master_mode = 0; addr_match = 1; late_sel = 1;
    do_start("R4 start");
    frame(9, 1, 1, 0, "R4 match");
    rel_start_req = 1; tick(1'b0, 1'b0, "R9 target start req ignored");
    rel_stop_req = 1;  tick(1'b0, 1'b0, "R9 target stop req ignored");
    ack_level = 0; rel_wait = 1; x_hold = 0; x_ack = 0;
    tick(1'b0, 1'b0, "R8 target release");
    addr_match = 0; late_sel = 0;
    frame(8, 1, 0, 0, "R3 target data 8th");
    do_stop("R10 target stop");

    // target, extension code
    ext_code = 1; late_sel = 1;
    do_start("R5 start");
    frame(8, 1, 0, 0, "R5 ext code");
    do_stop("R5 stop");

    // target, not addressed
    ext_code = 0;
    do_start("R6 start");
    frame(0, 0, 0, 0, "R6 no match addr");
    frame(0, 0, 0, 0, "R6 no match data");
    do_stop("R6 stop");

    // target, not addressed after repeated start
    restart_flag = 1;
    do_start("R7 restart");
    frame(9, 0, 0, 0, "R7 mismatch restart");
    restart_flag = 0;
    do_stop("R7 stop");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule